// File: doc/BRIEF.md
# Multichannel Interval-to-Pulse Transmit Sequencer

This block runs the transmit side of a multichannel acquisition front end. When a frame trigger arrives, it raises one common sample strobe so that every channel captures its value at the same instant. It then services the channels one at a time, from index 0 upward. For each channel it issues a one-cycle select pulse. It then watches the comparator output of the shared voltage-to-time converter and marks the high interval on a single serial line with two narrow pulses: a START pulse when the interval opens and a STOP pulse when it closes.

A fixed quiet gap follows every STOP, so the receiver can tell one channel from the next. If the comparator interval does not close within a timeout, the sequencer closes it on its own and raises a sticky error flag. After the last channel it pulses a frame-done flag and returns to idle.

The analog parts (integrator, multiplexer, optical driver) sit outside the block. They are seen only as the comparator input and the strobe, select and line outputs.

Top module: `iv_tx_sequencer`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, these outputs are 0: sample_o, ch_sel_o, line_o, frame_done_o and err_o. In the same cycles ch_idx_o is 0.
- R2: A frame_start_i seen high at a clock edge while idle makes sample_o high for exactly the next cycle. ch_sel_o for channel 0 follows in the cycle after that.
- R3: Within a frame, ch_sel_o is a one-cycle pulse that occurs once per channel. ch_idx_o carries the channel index, which runs 0, 1, ... N_CH-1 in ascending order.
- R4: In the wait-for-rise phase after a select, the first edge at which cmp_i is high starts a START pulse. That pulse drives line_o high for exactly PULSE_W cycles, beginning in the next cycle.
- R5: The first edge after START at which cmp_i is low (in the wait-for-fall phase) requests STOP. STOP is a line_o pulse of PULSE_W cycles that begins in the next cycle, or one cycle after START's last high cycle if that is later. At least one low cycle always separates START and STOP.
- R6: After the last high cycle of a STOP pulse, line_o stays low for exactly BLANK_W cycles. The next channel's ch_sel_o is then asserted, or the frame ends.
- R7: frame_done_o is high for exactly the one cycle that follows the blank gap of channel N_CH-1. In that cycle the block is idle and accepts a new trigger.
- R8: frame_start_i has no effect while a frame is in progress.
- R9: Timeout counting starts in the cycle after the select. If the interval has not been seen closing within TIMEOUT counted cycles, the block forces the missing pulses. A missing START is emitted at once, and STOP follows under the R5 spacing rule. err_o rises one cycle after expiry and stays high until reset.
- R10: The channel count N_CH is a parameter (default 64). Every frame services exactly N_CH channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Frame trigger, sampled while idle |
| cmp_i | input | 1 | Comparator interval, high while converting (synchronous) |
| sample_o | output | 1 | Common sample strobe to all channels |
| ch_sel_o | output | 1 | Channel select pulse, starts a conversion |
| ch_idx_o | output | $clog2(N_CH) | Index of the channel being serviced |
| line_o | output | 1 | Serial line carrying START/STOP pulses |
| frame_done_o | output | 1 | One-cycle pulse at the end of a frame |
| err_o | output | 1 | Sticky timeout error |

## Verification
The assertions assume that cmp_i is already synchronous to clk_i. They also assume that cmp_i is low when a select is issued, unless the previous interval was cut short by a timeout and the comparator is still high. The bench drives cmp_i on the falling edge from a small comparator emulator. The emulator answers each select after a short delay, with a high time chosen per frame and per channel. It covers a one-cycle interval, an interval that never rises and an interval longer than the timeout, and the long interval closes before the next select. Triggers are driven only on falling edges, including one issued in the middle of a frame.

// File: rtl/iv_tx_pkg.sv
package iv_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_SELECT,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_BLANK
  } seq_state_e;
endpackage

// File: rtl/iv_pulse_gen.sv
module iv_pulse_gen #(
  parameter int PULSE_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic line_o,
  output logic idle_o
);
  localparam int CW = $clog2(PULSE_W + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (fire_i)            cnt_q <= CW'(PULSE_W);
    else if (cnt_q != '0)       cnt_q <= cnt_q - CW'(1);
  end

  assign line_o = (cnt_q != '0);
  assign idle_o = (cnt_q == '0);

  // R5: a new pulse never starts on top of a running one
  a_r5_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> !line_o);
  // R4: a fired pulse is high in the next cycle
  a_r4_pulse_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> line_o);
endmodule

// File: rtl/iv_tmo_timer.sv
module iv_tmo_timer #(
  parameter int TIMEOUT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic exp_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (run_i) begin
      if (cnt_q == CW'(TIMEOUT - 1)) exp_q <= 1'b1;
      else                           cnt_q <= cnt_q + CW'(1);
    end
  end

  assign exp_o = exp_q;

  // R9: expiry holds until the next select clears it
  a_r9_exp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_o && !clr_i) |=> exp_o);
endmodule

// File: rtl/iv_tx_sequencer.sv
module iv_tx_sequencer
  import iv_tx_pkg::*;
#(
  parameter int N_CH    = 64,
  parameter int PULSE_W = 2,
  parameter int BLANK_W = 4,
  parameter int TIMEOUT = 4096
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          frame_start_i,
  input  logic                          cmp_i,
  output logic                          sample_o,
  output logic                          ch_sel_o,
  output logic [$clog2(N_CH)-1:0]       ch_idx_o,
  output logic                          line_o,
  output logic                          frame_done_o,
  output logic                          err_o
);
  localparam int CH_W = $clog2(N_CH);
  localparam int BL_W = $clog2(BLANK_W + 1);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

  seq_state_e      st_q;
  logic [CH_W-1:0] ch_q;
  logic [BL_W-1:0] bcnt_q;
  logic            end_seen_q, err_q, done_q;

  logic line_idle, tmo_exp;
  logic fire_start, fire_stop, ended, tmo_run, blank_last;

  always_comb begin
    ended      = end_seen_q || (st_q == ST_WAIT_LO && !cmp_i);
    fire_start = (st_q == ST_WAIT_HI) && (cmp_i || tmo_exp);
    fire_stop  = (st_q == ST_WAIT_LO) && (ended || tmo_exp) && line_idle;
    tmo_run    = (st_q == ST_WAIT_HI || st_q == ST_WAIT_LO) && !ended && !tmo_exp;
    blank_last = (bcnt_q == BL_W'(BLANK_W - 1));
  end

  iv_pulse_gen #(.PULSE_W(PULSE_W)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire_start | fire_stop),
    .line_o (line_o),
    .idle_o (line_idle)
  );

  iv_tmo_timer #(.TIMEOUT(TIMEOUT)) u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q == ST_SELECT),
    .run_i  (tmo_run),
    .exp_o  (tmo_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ch_q       <= '0;
      bcnt_q     <= '0;
      end_seen_q <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      err_q  <= err_q | tmo_exp;
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (frame_start_i) begin
          st_q <= ST_SAMPLE;
          ch_q <= '0;
        end
        ST_SAMPLE: st_q <= ST_SELECT;
        ST_SELECT: begin
          end_seen_q <= 1'b0;
          st_q       <= ST_WAIT_HI;
        end
        ST_WAIT_HI: if (fire_start) st_q <= ST_WAIT_LO;
        ST_WAIT_LO: begin
          if (!cmp_i) end_seen_q <= 1'b1;
          if (fire_stop) begin
            st_q   <= ST_BLANK;
            bcnt_q <= '0;
          end
        end
        ST_BLANK: if (line_idle) begin
          if (!blank_last) begin
            bcnt_q <= bcnt_q + BL_W'(1);
          end else if (ch_q == LAST_CH) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            ch_q <= ch_q + CH_W'(1);
            st_q <= ST_SELECT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sample_o     = (st_q == ST_SAMPLE);
  assign ch_sel_o     = (st_q == ST_SELECT);
  assign ch_idx_o     = ch_q;
  assign frame_done_o = done_q;
  assign err_o        = err_q;

  // R2: strobe is followed directly by the first select
  a_r2_sample_then_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> (ch_sel_o && ch_idx_o == '0));
  // R3: select is a single-cycle pulse
  a_r3_sel_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_sel_o |=> !ch_sel_o);
  // R3: index only steps up by one or restarts at zero
  a_r3_idx_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ch_idx_o) |-> (ch_idx_o == $past(ch_idx_o) + CH_W'(1) || ch_idx_o == '0));
  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  // R9: error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R6: no line activity while a select is issued
  a_r6_quiet_at_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_sel_o |-> !line_o);
endmodule

// File: tb/iv_tx_sequencer_tb.sv
module iv_tx_sequencer_tb;
  localparam int N   = 4;
  localparam int PW  = 2;
  localparam int BW  = 3;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0;
  logic cmp = 1'b0;
  logic sample, sel, line, done, err;
  logic [$clog2(N)-1:0] idx;

  always #4 clk = ~clk;

  iv_tx_sequencer #(.N_CH(N), .PULSE_W(PW), .BLANK_W(BW), .TIMEOUT(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .cmp_i(cmp),
    .sample_o(sample), .ch_sel_o(sel), .ch_idx_o(idx), .line_o(line),
    .frame_done_o(done), .err_o(err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_ph = 0, m_ch = 0, m_pl = 0, m_tmo = 0, m_bl = 0;
  bit m_exp = 0, m_end = 0, m_err = 0, m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ch = 0; m_pl = 0; m_tmo = 0; m_bl = 0;
      m_exp = 0; m_end = 0; m_err = 0; m_done = 0;
    end else begin
      int  pl_now;
      bit  exp_now, fired, ended, run;
      pl_now  = m_pl;
      exp_now = m_exp;
      fired   = 0;
      run     = 0;
      m_err   = m_err | exp_now;
      m_done  = 0;
      if (m_pl > 0) m_pl--;
      case (m_ph)
        0: if (fs) begin m_ph = 1; m_ch = 0; end
        1: m_ph = 2;
        2: begin m_tmo = 0; m_exp = 0; m_end = 0; m_ph = 3; end
        3: begin
          run = !exp_now;
          if (cmp || exp_now) begin fired = 1; m_ph = 4; end
        end
        4: begin
          ended = m_end || !cmp;
          run = !ended && !exp_now;
          if (!cmp) m_end = 1;
          if ((ended || exp_now) && pl_now == 0) begin fired = 1; m_ph = 5; m_bl = 0; end
        end
        5: if (pl_now == 0) begin
          if (m_bl != BW - 1) m_bl++;
          else if (m_ch == N - 1) begin m_ph = 0; m_done = 1; end
          else begin m_ch++; m_ph = 2; end
        end
        default: m_ph = 0;
      endcase
      if (fired) m_pl = PW;
      if (run) begin
        if (m_tmo == TMO - 1) m_exp = 1;
        else m_tmo++;
      end
    end
  end

  // ---------------- comparator emulator ----------------
  int fr = -1;
  int dcnt = 0, hcnt = 0;
  int edges = 0, exp_idx = 0;
  logic line_d = 1'b0;

  function automatic int pat_len(input int f, input int c);
    if (f == 0) return (c == 1) ? 1 : 2 + 3 * c;
    if (f == 1) return (c == 2) ? 0 : (c == 3) ? TMO + 3 : 4;
    return 5 + c;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      // per-cycle comparison against the model
      chk(sample == (m_ph == 1), "R2 sample_o", sample, m_ph == 1);
      chk(sel == (m_ph == 2), "R3 ch_sel_o", sel, m_ph == 2);
      chk(int'(idx) == m_ch, "R3 ch_idx_o", idx, m_ch);
      chk(line == (m_pl > 0), "R4 R5 R6 R8 line_o", line, m_pl > 0);
      chk(done == m_done, "R7 frame_done_o", done, m_done);
      chk(err == m_err, "R9 err_o", err, m_err);
      if (sample) begin fr++; edges = 0; exp_idx = 0; end
      if (line && !line_d) edges++;
      if (sel) begin
        chk(int'(idx) == exp_idx, "R3 order", idx, exp_idx);
        exp_idx++;
      end
      if (done) begin
        chk(edges == 2 * N, "R4 R5 pulse count", edges, 2 * N);
        chk(exp_idx == N, "R10 channels per frame", exp_idx, N);
      end
      line_d = line;
      // drive comparator
      if (sel) begin
        dcnt = 1 + (int'(idx) % 3);
        hcnt = pat_len(fr, int'(idx));
        cmp  = 1'b0;
      end else if (dcnt > 0) begin
        dcnt--;
        if (dcnt == 0 && hcnt > 0) cmp = 1'b1;
      end else if (hcnt > 0) begin
        hcnt--;
        if (hcnt == 0) cmp = 1'b0;
      end
    end else begin
      fr = -1; dcnt = 0; hcnt = 0; cmp = 1'b0; line_d = 1'b0;
    end
  end

  task automatic pulse_fs();
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic chk_reset_state(input string tag);
    chk(!sample && !sel && !line && !done && !err && idx == '0, tag,
        {sample, sel, line, done, err, idx != '0}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("R1 after reset");
    // frame 0: normal, including a one-cycle interval (hold-off)
    pulse_fs();
    wait_done();
    // frame 1: timeouts plus a trigger issued mid-frame (ignored)
    pulse_fs();
    repeat (12) @(negedge clk);
    fs = 1'b1; @(negedge clk); fs = 1'b0;
    wait_done();
    chk(err == 1'b1, "R9 sticky after timeout", err, 1);
    // frame 2: normal, error must stay set
    pulse_fs();
    wait_done();
    chk(err == 1'b1, "R9 still set", err, 1);
    // mid-frame reset
    pulse_fs();
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_reset_state("R1 async reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("R1 after second reset");
    pulse_fs();
    wait_done();
    chk(err == 1'b0, "R9 clean frame no error", err, 0);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule